// File: doc/BRIEF.md
# Synchronous Serial Receive Start Controller

This block decides the cycle in which a synchronous serial receiver begins capturing a word, and it conditions the receive clock that the capture logic uses. It runs on one system clock. Candidate receive clocks arrive as synchronous levels. A multiplexer picks one of them, and its rising and falling transitions are turned into one-cycle ticks. A gate driven by frame sync then qualifies those ticks. A selectable inversion decides which transition samples incoming data and which one updates the frame sync output.

The frame sync input is asynchronous. It passes through a synchronizer, and its edges are found by comparing each new sample with the one before. A nine-way start selector chooses what begins a word: continuous operation, the transmit-start pulse, a frame-sync level, a frame-sync edge, or a compare-match pulse. A small state machine has three states: OFF, ARMED and RECV. The transitions are named as follows. ENABLE goes from OFF to ARMED. TRIGGER goes from ARMED to RECV and pulses the start strobe. REARM goes from RECV to ARMED on word-done. RESTART stays in RECV on word-done when the start condition already holds in that cycle, and pulses the strobe again. DISABLE goes from any state to OFF when the enable input is low. A separate field decides whether the receive clock pin is driven out continuously, only during a word, or not at all.

Top module: `rx_start_ctrl`

## Requirements
- R1: With start_sel = 0 (continuous), rx_start pulses at the second falling clock edge after rx_enable rises. A word_done pulse while a word is in progress produces another rx_start in the very next cycle.
- R2: With start_sel = 1, a tx_start pulse while armed starts a word. A cmp_match pulse does not.
- R3: With start_sel = 2, a word starts while synchronized frame sync is low. With start_sel = 3, a word starts while it is high. The opposite level does not start a word.
- R4: With start_sel = 4, a word starts on a falling frame-sync edge. With start_sel = 5, a word starts on a rising edge. The other edge direction does not start a word.
- R5: start_sel = 6 and start_sel = 7 both start a word on either frame-sync edge. start_sel = 8 starts a word on cmp_match, and tx_start has no effect in that mode. Codes 9 to 15 never start a word, whatever the inputs do.
- R6: rx_start is one cycle wide and appears only when entering or staying in RECV. While RECV is held without word_done, no further start occurs. After word_done, a trigger that is present in the same cycle as word_done starts the next word at once. With rx_enable low, no start occurs.
- R7: Frame sync passes through a two-flop synchronizer. A start caused by an fs_in edge shows up three rising clock edges after fs_in changes and lasts one cycle.
- R8: With gate_sel = 0, rx_clk_en is always 1. With gate_sel = 1, rx_clk_en is 1 only while synchronized frame sync is low. With gate_sel = 2, it is 1 only while frame sync is high. gate_sel = 3 holds rx_clk_en at 0. While rx_clk_en is 0, both ticks are suppressed.
- R9: With invert_edge = 1, sample_tick marks rising transitions of the selected clock and fs_drive_tick marks falling ones. With invert_edge = 0, these are swapped. sample_on_rise equals invert_edge.
- R10: src_sel = 0, 1 and 2 select div_clk, tx_clk and pin_clk respectively, and src_sel = 3 selects a constant 0. clk_out follows the selected clock one cycle later, and invert_edge has no effect on it.
- R11: clkout_sel = 0 or 3 keeps clk_oe at 0. clkout_sel = 1 sets clk_oe equal to rx_enable. clkout_sel = 2 sets clk_oe only while a word is in progress (rx_busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable |
| div_clk | input | 1 | Divided clock level (synchronous) |
| tx_clk | input | 1 | Transmit clock level (synchronous) |
| pin_clk | input | 1 | Clock pin level, already synchronized |
| fs_in | input | 1 | Frame sync, asynchronous |
| tx_start | input | 1 | Transmitter start pulse |
| cmp_match | input | 1 | Compare-0 match pulse |
| word_done | input | 1 | Current word finished pulse |
| start_sel | input | 4 | Start condition code |
| gate_sel | input | 2 | Clock gating code |
| invert_edge | input | 1 | Sampling edge inversion |
| clkout_sel | input | 2 | Clock output mode code |
| src_sel | input | 2 | Receive clock source code |
| rx_start | output | 1 | One-cycle start strobe |
| rx_busy | output | 1 | Word in progress (RECV state) |
| rx_clk_en | output | 1 | Gated receive clock enable |
| sample_tick | output | 1 | Data and frame sync sampling tick |
| fs_drive_tick | output | 1 | Frame sync output update tick |
| sample_on_rise | output | 1 | 1 when sampling is on the rising edge |
| clk_out | output | 1 | Receive clock level driven to the pin |
| clk_oe | output | 1 | Clock pin output enable |

## Verification
A word_done pulse and a start trigger can arrive in the same cycle. The end of one word then meets the condition that begins the next. The bench creates this collision by raising fs_in under a rising-edge start code and asserting word_done exactly in the cycle where the synchronized edge becomes visible. It expects rx_start in the following cycle rather than a lost edge. The continuous code makes the same collision happen on every word_done. There the bench checks that the restart strobe appears one cycle after word_done and that only one strobe appears.

// File: rtl/rxs_pkg.sv
`timescale 1ns/1ps
package rxs_pkg;

    localparam int START_SEL_W = 4;
    localparam int GATE_SEL_W  = 2;
    localparam int OUT_SEL_W   = 2;
    localparam int SRC_SEL_W   = 2;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RECV  = 2'd2
    } rx_state_e;

    typedef enum logic [START_SEL_W-1:0] {
        SC_CONT    = 4'd0,
        SC_TXSTART = 4'd1,
        SC_FS_LOW  = 4'd2,
        SC_FS_HIGH = 4'd3,
        SC_FS_FALL = 4'd4,
        SC_FS_RISE = 4'd5,
        SC_FS_CHG  = 4'd6,
        SC_FS_EDGE = 4'd7,
        SC_CMP     = 4'd8
    } start_code_e;

    typedef enum logic [GATE_SEL_W-1:0] {
        GT_FREE    = 2'd0,
        GT_FS_LOW  = 2'd1,
        GT_FS_HIGH = 2'd2,
        GT_RSVD    = 2'd3
    } gate_code_e;

    typedef enum logic [OUT_SEL_W-1:0] {
        CO_INPUT = 2'd0,
        CO_CONT  = 2'd1,
        CO_XFER  = 2'd2,
        CO_RSVD  = 2'd3
    } clkout_code_e;

    typedef enum logic [SRC_SEL_W-1:0] {
        CS_DIV  = 2'd0,
        CS_TX   = 2'd1,
        CS_PIN  = 2'd2,
        CS_RSVD = 2'd3
    } src_code_e;

endpackage

// File: rtl/rxs_fs_sync.sv
`timescale 1ns/1ps
module rxs_fs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_async,
    output logic fs_lvl,
    output logic fs_rise,
    output logic fs_fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          fs_prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= fs_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[LAST-1:0], fs_async};
            end
        end
    endgenerate

    // previous synchronized sample for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_prev <= 1'b0;
        else        fs_prev <= chain[LAST];
    end

    assign fs_lvl  = chain[LAST];
    assign fs_rise =  chain[LAST] & ~fs_prev;
    assign fs_fall = ~chain[LAST] &  fs_prev;

endmodule

// File: rtl/rxs_clk_cond.sv
`timescale 1ns/1ps
module rxs_clk_cond
    import rxs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  div_clk,
    input  logic                  tx_clk,
    input  logic                  pin_clk,
    input  logic [SRC_SEL_W-1:0]  src_sel,
    input  logic [GATE_SEL_W-1:0] gate_sel,
    input  logic                  invert_edge,
    input  logic [OUT_SEL_W-1:0]  clkout_sel,
    input  logic                  fs_lvl,
    input  logic                  rx_enable,
    input  logic                  busy,
    output logic                  rx_clk_en,
    output logic                  sample_tick,
    output logic                  fs_drive_tick,
    output logic                  sample_on_rise,
    output logic                  clk_out,
    output logic                  clk_oe
);
    logic sel_clk;
    logic rclk_q;
    logic rclk_p;
    logic rclk_rise;
    logic rclk_fall;
    logic gate_ok;

    // source multiplexer
    always_comb begin
        unique case (src_sel)
            CS_DIV:  sel_clk = div_clk;
            CS_TX:   sel_clk = tx_clk;
            CS_PIN:  sel_clk = pin_clk;
            default: sel_clk = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rclk_q <= 1'b0;
            rclk_p <= 1'b0;
        end else begin
            rclk_q <= sel_clk;
            rclk_p <= rclk_q;
        end
    end

    assign rclk_rise =  rclk_q & ~rclk_p;
    assign rclk_fall = ~rclk_q &  rclk_p;

    // frame-sync based gating
    always_comb begin
        unique case (gate_sel)
            GT_FREE:    gate_ok = 1'b1;
            GT_FS_LOW:  gate_ok = ~fs_lvl;
            GT_FS_HIGH: gate_ok = fs_lvl;
            default:    gate_ok = 1'b0;
        endcase
    end

    // output enable for the clock pin
    always_comb begin
        unique case (clkout_sel)
            CO_CONT: clk_oe = rx_enable;
            CO_XFER: clk_oe = busy;
            default: clk_oe = 1'b0;
        endcase
    end

    assign rx_clk_en      = gate_ok;
    assign sample_tick    = gate_ok & (invert_edge ? rclk_rise : rclk_fall);
    assign fs_drive_tick  = gate_ok & (invert_edge ? rclk_fall : rclk_rise);
    assign sample_on_rise = invert_edge;
    assign clk_out        = rclk_q;

    // R9: sampling and frame-sync update never share a cycle
    a_r9_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_tick && fs_drive_tick));

    // R8: reserved gating code blocks every tick
    a_r8_reserved_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_sel == GT_RSVD) |-> (!sample_tick && !fs_drive_tick && !rx_clk_en));

    // R10: driven clock is the selected source one cycle late, never inverted
    a_r10_clkout_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (clk_out == $past(sel_clk)));

endmodule

// File: rtl/rxs_start_fsm.sv
`timescale 1ns/1ps
module rxs_start_fsm
    import rxs_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_enable,
    input  logic [START_SEL_W-1:0] start_sel,
    input  logic                   fs_lvl,
    input  logic                   fs_rise,
    input  logic                   fs_fall,
    input  logic                   tx_start,
    input  logic                   cmp_match,
    input  logic                   word_done,
    output logic                   rx_start,
    output logic                   busy
);
    rx_state_e state_q;
    rx_state_e state_d;
    logic      trig;
    logic      fire;
    logic      start_q;

    // start condition selector
    always_comb begin
        unique case (start_sel)
            SC_CONT:    trig = 1'b1;
            SC_TXSTART: trig = tx_start;
            SC_FS_LOW:  trig = ~fs_lvl;
            SC_FS_HIGH: trig = fs_lvl;
            SC_FS_FALL: trig = fs_fall;
            SC_FS_RISE: trig = fs_rise;
            SC_FS_CHG:  trig = fs_rise | fs_fall;
            SC_FS_EDGE: trig = fs_rise | fs_fall;
            SC_CMP:     trig = cmp_match;
            default:    trig = 1'b0;
        endcase
    end

    // TRIGGER from ARMED, or RESTART when a word ends with the condition present
    assign fire = rx_enable && trig &&
                  ((state_q == ST_ARMED) || (state_q == ST_RECV && word_done));

    always_comb begin
        state_d = state_q;
        if (!rx_enable) begin
            state_d = ST_OFF;                       // DISABLE
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_ARMED;       // ENABLE
                ST_ARMED: if (fire) state_d = ST_RECV;   // TRIGGER
                ST_RECV:  if (word_done && !fire) state_d = ST_ARMED; // REARM
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= fire;
    end

    assign rx_start = start_q;
    assign busy     = (state_q == ST_RECV);

    // R6: a strobe always coincides with a word in progress
    a_r6_start_in_recv: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |-> busy);

    // R6: no new strobe while a word runs without word_done
    a_r6_no_start_mid_word: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(word_done)) |-> !rx_start);

    // R6: strobe requires the receiver to have been enabled
    a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |-> $past(rx_enable));

    // R5: reserved start codes never start a word
    a_r5_reserved_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_sel) > 4'd8) |-> !rx_start);

endmodule

// File: rtl/rx_start_ctrl.sv
`timescale 1ns/1ps
module rx_start_ctrl
    import rxs_pkg::*;
#(
    parameter int FS_SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_enable,
    input  logic                   div_clk,
    input  logic                   tx_clk,
    input  logic                   pin_clk,
    input  logic                   fs_in,
    input  logic                   tx_start,
    input  logic                   cmp_match,
    input  logic                   word_done,
    input  logic [START_SEL_W-1:0] start_sel,
    input  logic [GATE_SEL_W-1:0]  gate_sel,
    input  logic                   invert_edge,
    input  logic [OUT_SEL_W-1:0]   clkout_sel,
    input  logic [SRC_SEL_W-1:0]   src_sel,
    output logic                   rx_start,
    output logic                   rx_busy,
    output logic                   rx_clk_en,
    output logic                   sample_tick,
    output logic                   fs_drive_tick,
    output logic                   sample_on_rise,
    output logic                   clk_out,
    output logic                   clk_oe
);
    logic fs_lvl;
    logic fs_rise;
    logic fs_fall;
    logic busy;

    rxs_fs_sync #(
        .STAGES   (FS_SYNC_STAGES)
    ) i_fs_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_async (fs_in),
        .fs_lvl   (fs_lvl),
        .fs_rise  (fs_rise),
        .fs_fall  (fs_fall)
    );

    rxs_start_fsm i_start_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_enable (rx_enable),
        .start_sel (start_sel),
        .fs_lvl    (fs_lvl),
        .fs_rise   (fs_rise),
        .fs_fall   (fs_fall),
        .tx_start  (tx_start),
        .cmp_match (cmp_match),
        .word_done (word_done),
        .rx_start  (rx_start),
        .busy      (busy)
    );

    rxs_clk_cond i_clk_cond (
        .clk            (clk),
        .rst_n          (rst_n),
        .div_clk        (div_clk),
        .tx_clk         (tx_clk),
        .pin_clk        (pin_clk),
        .src_sel        (src_sel),
        .gate_sel       (gate_sel),
        .invert_edge    (invert_edge),
        .clkout_sel     (clkout_sel),
        .fs_lvl         (fs_lvl),
        .rx_enable      (rx_enable),
        .busy           (busy),
        .rx_clk_en      (rx_clk_en),
        .sample_tick    (sample_tick),
        .fs_drive_tick  (fs_drive_tick),
        .sample_on_rise (sample_on_rise),
        .clk_out        (clk_out),
        .clk_oe         (clk_oe)
    );

    assign rx_busy = busy;

    // R11: transfer-only output mode drives the pin only during a word
    a_r11_xfer_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (clkout_sel == CO_XFER && !rx_busy) |-> !clk_oe);

endmodule

// File: tb/test_rx_start_ctrl.sv
`timescale 1ns/1ps
module test_rx_start_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0;
    logic       div_clk = 1'b0, tx_clk = 1'b0, pin_clk = 1'b0;
    logic       fs_in = 1'b0, tx_start = 1'b0, cmp_match = 1'b0, word_done = 1'b0;
    logic [3:0] start_sel = 4'd0;
    logic [1:0] gate_sel = 2'd0;
    logic       invert_edge = 1'b0;
    logic [1:0] clkout_sel = 2'd0;
    logic [1:0] src_sel = 2'd0;
    logic       rx_start, rx_busy, rx_clk_en, sample_tick, fs_drive_tick;
    logic       sample_on_rise, clk_out, clk_oe;

    int checks = 0;
    int errors = 0;
    int cnt    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rx_start_ctrl i_rx_start_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .div_clk(div_clk), .tx_clk(tx_clk), .pin_clk(pin_clk),
        .fs_in(fs_in), .tx_start(tx_start), .cmp_match(cmp_match),
        .word_done(word_done), .start_sel(start_sel), .gate_sel(gate_sel),
        .invert_edge(invert_edge), .clkout_sel(clkout_sel), .src_sel(src_sel),
        .rx_start(rx_start), .rx_busy(rx_busy), .rx_clk_en(rx_clk_en),
        .sample_tick(sample_tick), .fs_drive_tick(fs_drive_tick),
        .sample_on_rise(sample_on_rise), .clk_out(clk_out), .clk_oe(clk_oe)
    );

    // vector: {code[3:0], fs_init, fs_final, tx_pulse, cmp_pulse, expected_starts}
    localparam int NV = 18;
    localparam logic [8:0] VECS [NV] = '{
        {4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R1 continuous
        {4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R2 tx start
        {4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 cmp ignored
        {4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 low level
        {4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 stays high
        {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R3 high level
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 stays low
        {4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 falling
        {4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 rising ignored
        {4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 rising
        {4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 falling ignored
        {4'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R5 change
        {4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 any edge
        {4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 no edge
        {4'd8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R5 compare
        {4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 tx ignored
        {4'd9, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R5 reserved
        {4'd15, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}  // R5 reserved
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (rx_start === 1'b1) cnt++;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic quiesce();
        rx_enable = 1'b0; word_done = 1'b0; tx_start = 1'b0; cmp_match = 1'b0;
        steps(5);
        cnt = 0;
    endtask

    initial begin
        steps(3);
        // reset state
        chk("R6", "reset rx_start", {31'd0, rx_start}, 0);
        chk("R6", "reset rx_busy", {31'd0, rx_busy}, 0);
        chk("R8", "reset rx_clk_en free", {31'd0, rx_clk_en}, 1);
        chk("R11", "reset clk_oe", {31'd0, clk_oe}, 0);
        rst_n = 1'b1;
        steps(2);

        // table of start-condition vectors
        for (int v = 0; v < NV; v++) begin
            logic [8:0] e;
            e = VECS[v];
            rx_enable = 1'b0;
            start_sel = e[8:5];
            fs_in = e[4];
            steps(5);
            cnt = 0;
            rx_enable = 1'b1;
            steps(4);
            fs_in = e[3]; tx_start = e[2]; cmp_match = e[1];
            step();
            tx_start = 1'b0; cmp_match = 1'b0;
            steps(6);
            chk("R1-5 vec", $sformatf("code %0d start count", e[8:5]), cnt, {31'd0, e[0]});
        end

        // R1: timing of continuous start and restart on word_done
        quiesce();
        start_sel = 4'd0; fs_in = 1'b0;
        rx_enable = 1'b1;
        step();
        chk("R1", "no start after one edge", {31'd0, rx_start}, 0);
        step();
        chk("R1", "start at second edge", {31'd0, rx_start}, 1);
        step();
        chk("R1", "start one cycle wide", {31'd0, rx_start}, 0);
        steps(2);
        word_done = 1'b1;
        step();
        word_done = 1'b0;
        chk("R1", "restart right after word_done", {31'd0, rx_start}, 1);
        step();
        chk("R1", "single restart strobe", {31'd0, rx_start}, 0);

        // R7: synchronizer latency
        quiesce();
        start_sel = 4'd5; fs_in = 1'b0;
        rx_enable = 1'b1;
        steps(4);
        fs_in = 1'b1;
        steps(2);
        chk("R7", "no start after two edges", {31'd0, rx_start}, 0);
        step();
        chk("R7", "start after three edges", {31'd0, rx_start}, 1);
        step();
        chk("R7", "start lasts one cycle", {31'd0, rx_start}, 0);

        // R6: suppression while busy, re-arm by word_done
        cnt = 0;
        fs_in = 1'b0; steps(3); fs_in = 1'b1; steps(4);
        chk("R6", "edge ignored mid word", cnt, 0);
        chk("R6", "still busy", {31'd0, rx_busy}, 1);
        word_done = 1'b1; step(); word_done = 1'b0;
        chk("R6", "word_done rearms", {31'd0, rx_busy}, 0);
        fs_in = 1'b0; steps(3); fs_in = 1'b1; steps(4);
        chk("R6", "start after rearm", cnt, 1);

        // R6: word_done in the same cycle as a synchronized edge
        fs_in = 1'b0; steps(3);
        cnt = 0;
        fs_in = 1'b1;
        steps(2);
        word_done = 1'b1;
        step();
        word_done = 1'b0;
        chk("R6", "coincident edge and word_done start", {31'd0, rx_start}, 1);
        chk("R6", "still busy after restart", {31'd0, rx_busy}, 1);

        // R6: disabled receiver never starts
        quiesce();
        start_sel = 4'd0;
        steps(6);
        chk("R6", "no start while disabled", cnt, 0);

        // R8: gating
        gate_sel = 2'd1; fs_in = 1'b1; steps(4);
        chk("R8", "gate low blocks when fs high", {31'd0, rx_clk_en}, 0);
        invert_edge = 1'b1; src_sel = 2'd0; div_clk = 1'b1; step();
        chk("R8", "gated sample tick", {31'd0, sample_tick}, 0);
        div_clk = 1'b0; steps(2);
        fs_in = 1'b0; steps(4);
        chk("R8", "gate low passes when fs low", {31'd0, rx_clk_en}, 1);
        gate_sel = 2'd2; step();
        chk("R8", "gate high blocks when fs low", {31'd0, rx_clk_en}, 0);
        fs_in = 1'b1; steps(4);
        chk("R8", "gate high passes when fs high", {31'd0, rx_clk_en}, 1);
        gate_sel = 2'd3; step();
        chk("R8", "reserved gate closed", {31'd0, rx_clk_en}, 0);
        gate_sel = 2'd0; step();
        chk("R8", "free running", {31'd0, rx_clk_en}, 1);

        // R9/R10: edge selection and non-inverted output clock
        for (int inv = 0; inv < 2; inv++) begin
            invert_edge = inv[0];
            div_clk = 1'b0; steps(3);
            div_clk = 1'b1; step();
            chk("R9", "sample tick on rise", {31'd0, sample_tick}, inv);
            chk("R9", "drive tick on rise", {31'd0, fs_drive_tick}, 1 - inv);
            chk("R9", "sample_on_rise", {31'd0, sample_on_rise}, inv);
            chk("R10", "clk_out not inverted", {31'd0, clk_out}, 1);
            div_clk = 1'b0; step();
            chk("R9", "sample tick on fall", {31'd0, sample_tick}, 1 - inv);
            chk("R9", "drive tick on fall", {31'd0, fs_drive_tick}, inv);
        end

        // R10: source select
        src_sel = 2'd1; div_clk = 1'b1; tx_clk = 1'b0; steps(2);
        chk("R10", "tx source ignores div_clk", {31'd0, clk_out}, 0);
        tx_clk = 1'b1; steps(2);
        chk("R10", "tx source follows tx_clk", {31'd0, clk_out}, 1);
        src_sel = 2'd2; pin_clk = 1'b0; steps(2);
        chk("R10", "pin source", {31'd0, clk_out}, 0);
        src_sel = 2'd3; pin_clk = 1'b1; steps(2);
        chk("R10", "reserved source is zero", {31'd0, clk_out}, 0);
        div_clk = 1'b0; tx_clk = 1'b0; pin_clk = 1'b0; src_sel = 2'd0;

        // R11: clock output modes
        quiesce();
        start_sel = 4'd1; clkout_sel = 2'd2;
        rx_enable = 1'b1; steps(3);
        chk("R11", "xfer mode idle oe", {31'd0, clk_oe}, 0);
        tx_start = 1'b1; step(); tx_start = 1'b0; step();
        chk("R11", "xfer mode busy oe", {31'd0, clk_oe}, 1);
        word_done = 1'b1; step(); word_done = 1'b0;
        chk("R11", "xfer mode after word oe", {31'd0, clk_oe}, 0);
        clkout_sel = 2'd1; step();
        chk("R11", "continuous oe enabled", {31'd0, clk_oe}, 1);
        clkout_sel = 2'd3; step();
        chk("R11", "reserved oe", {31'd0, clk_oe}, 0);
        clkout_sel = 2'd0; step();
        chk("R11", "input-only oe", {31'd0, clk_oe}, 0);
        clkout_sel = 2'd1; rx_enable = 1'b0; step();
        chk("R11", "continuous oe disabled", {31'd0, clk_oe}, 0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule